// File: doc/BRIEF.md
# Load Queue with Memory-Order Violation Detection

This block keeps the in-flight loads of an out-of-order core in program order. Each slot holds the load's sequence number, its effective address and a flag saying whether that address has been computed yet. Loads enter at the young end. Commit retires them from the old end and squash discards them from the young end. The address of a load already in the queue is filled in when the load executes; the load is found by its sequence number.

When a store executes, its sequence number and address are checked against every slot in one cycle. A slot is a candidate when its load is younger than the store, its address is known and both addresses fall in the same 256-byte region. The oldest candidate becomes the recorded violator, and the store is told that it faulted. The record stays until the consumer reads it. While a record is held, later stores skip the search. The block also holds a blocked-load marker, which a squash clears once the squash reaches back past the blocked load.

A two-state machine holds the violator record. In `VIO_IDLE` no violator is held. The *capture* transition to `VIO_HELD` happens when an executing store finds a candidate. In `VIO_HELD` the record is presented at the outputs. The *release* transition back to `VIO_IDLE` happens on a read.

Top module: `ldq_order_guard`

## Requirements
- R1: After reset, `ldq_count` is 0 and `store_fault`, `vio_valid` and `blk_active` are all 0.
- R2: An asserted `alloc_valid` adds one load at the young end, and `ldq_count` rises by one after the clock edge. It is ignored when `ldq_count` equals DEPTH (8 by default) at the start of that cycle.
- R3: An asserted `commit_valid` removes every queued load whose sequence number is less than or equal to `commit_seq`. The removal starts at the oldest end and is complete in one cycle.
- R4: An asserted `squash_valid` removes every queued load whose sequence number is greater than `squash_seq`. A load allocated in the same cycle is kept and becomes the youngest entry.
- R5: A store with `store_valid` matches a load only if three conditions hold: the load's sequence number is strictly greater than `store_seq`, its address is known, and address bits [ADDR_W-1:8] are equal. On a match found while no record is held, `store_fault` is 1 for exactly the next cycle, and from that cycle on `vio_valid` is 1 and `vio_seq` holds the load's sequence number.
- R6: A load whose address has not been supplied through `exec_valid`/`exec_seq`/`exec_addr` never matches a store.
- R7: When several loads match, the one nearest the oldest end (the lowest sequence number) is recorded.
- R8: While `vio_valid` is 1, a store causes no search: `store_fault` stays 0 and `vio_seq` is unchanged. This holds even in a cycle that also reads the record.
- R9: Asserting `vio_read` while `vio_valid` is 1 clears `vio_valid` after the clock edge.
- R10: `blk_set` arms `blk_active` and stores `blk_seq`. A squash with `squash_seq` smaller than the stored number clears the marker. A squash with a larger or equal number leaves it armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate a load at the young end |
| alloc_seq | input | SEQ_W | Sequence number of the allocated load |
| exec_valid | input | 1 | A queued load has computed its address |
| exec_seq | input | SEQ_W | Sequence number of that load |
| exec_addr | input | ADDR_W | Its effective address |
| commit_valid | input | 1 | Retire loads up to `commit_seq` |
| commit_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Discard loads younger than `squash_seq` |
| squash_seq | input | SEQ_W | Squash boundary |
| store_valid | input | 1 | A store executes this cycle |
| store_seq | input | SEQ_W | Sequence number of the store |
| store_addr | input | ADDR_W | Address of the store |
| vio_read | input | 1 | Read and clear the violator record |
| blk_set | input | 1 | Arm the blocked-load marker |
| blk_seq | input | SEQ_W | Sequence number of the blocked load |
| ldq_count | output | CNT_W | Number of queued loads |
| store_fault | output | 1 | The store of the previous cycle caused a violation |
| vio_valid | output | 1 | A violator record is held |
| vio_seq | output | SEQ_W | Sequence number of the recorded load |
| blk_active | output | 1 | Blocked-load marker armed |

## Verification
The collision that matters is a store arriving in the same cycle as a read of a held record. The bench holds a record, then applies a store whose address would otherwise match in the same cycle as `vio_read`. It expects the record to be gone and no fault in the following cycle. A later store must then be searched and find the load it missed before. The bench also combines a squash with an allocation in one cycle and judges the result through `ldq_count` and through which load a later store records.

// File: rtl/ldq_pkg.sv
package ldq_pkg;
    typedef enum logic {
        VIO_IDLE = 1'b0,
        VIO_HELD = 1'b1
    } vio_state_e;
endpackage

// File: rtl/ldq_entries.sv
module ldq_entries #(
    parameter int DEPTH  = 8,
    parameter int SEQ_W  = 16,
    parameter int ADDR_W = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_valid,
    input  logic [SEQ_W-1:0]             alloc_seq,
    input  logic                         exec_valid,
    input  logic [SEQ_W-1:0]             exec_seq,
    input  logic [ADDR_W-1:0]            exec_addr,
    input  logic                         commit_valid,
    input  logic [SEQ_W-1:0]             commit_seq,
    input  logic                         squash_valid,
    input  logic [SEQ_W-1:0]             squash_seq,
    input  logic                         blk_set,
    input  logic [SEQ_W-1:0]             blk_seq,
    output logic [DEPTH-1:0]             slot_live,
    output logic [DEPTH-1:0]             slot_known,
    output logic [DEPTH-1:0][SEQ_W-1:0]  slot_seq,
    output logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    output logic [PTR_W-1:0]             head,
    output logic [CNT_W-1:0]             count,
    output logic                         blk_active
);
    logic [PTR_W-1:0] tail;
    logic [DEPTH-1:0] commit_hit, squash_hit;
    logic [CNT_W-1:0] commit_n, squash_n;
    logic [PTR_W-1:0] alloc_slot;
    logic             alloc_ok;
    logic [SEQ_W-1:0] blk_seq_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign commit_hit[i] = commit_valid && slot_live[i] && (slot_seq[i] <= commit_seq);
        assign squash_hit[i] = squash_valid && slot_live[i] && (slot_seq[i] > squash_seq);
    end

    assign count      = CNT_W'($countones(slot_live));
    assign commit_n   = CNT_W'($countones(commit_hit));
    assign squash_n   = CNT_W'($countones(squash_hit));
    assign alloc_ok   = alloc_valid && (count < CNT_W'(DEPTH));
    assign alloc_slot = tail - PTR_W'(squash_n);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_live  <= '0;
            slot_known <= '0;
            slot_seq   <= '0;
            slot_addr  <= '0;
            head       <= '0;
            tail       <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (commit_hit[i] || squash_hit[i]) begin
                    slot_live[i]  <= 1'b0;
                    slot_known[i] <= 1'b0;
                end else if (exec_valid && slot_live[i] && slot_seq[i] == exec_seq) begin
                    slot_known[i] <= 1'b1;
                    slot_addr[i]  <= exec_addr;
                end
            end
            if (alloc_ok) begin
                slot_live[alloc_slot]  <= 1'b1;
                slot_known[alloc_slot] <= 1'b0;
                slot_seq[alloc_slot]   <= alloc_seq;
            end
            head <= head + PTR_W'(commit_n);
            tail <= alloc_slot + PTR_W'(alloc_ok);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_active <= 1'b0;
            blk_seq_q  <= '0;
        end else if (blk_set) begin
            blk_active <= 1'b1;
            blk_seq_q  <= blk_seq;
        end else if (squash_valid && squash_seq < blk_seq_q) begin
            blk_active <= 1'b0;
        end
    end

    p_full_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (count == CNT_W'(DEPTH) && !commit_valid && !squash_valid) |=> count == CNT_W'(DEPTH));

    p_commit_shrink_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && !alloc_valid) |=> count <= $past(count));

    p_blk_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_active && !blk_set && squash_valid && squash_seq < blk_seq_q) |=> !blk_active);
endmodule

// File: rtl/ldq_vio_search.sv
module ldq_vio_search #(
    parameter int DEPTH        = 8,
    parameter int SEQ_W        = 16,
    parameter int ADDR_W       = 32,
    parameter int REGION_SHIFT = 8,
    localparam int PTR_W       = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]             slot_live,
    input  logic [DEPTH-1:0]             slot_known,
    input  logic [DEPTH-1:0][SEQ_W-1:0]  slot_seq,
    input  logic [DEPTH-1:0][ADDR_W-1:0] slot_addr,
    input  logic [PTR_W-1:0]             head,
    input  logic [SEQ_W-1:0]             store_seq,
    input  logic [ADDR_W-1:0]            store_addr,
    output logic                         hit,
    output logic [SEQ_W-1:0]             hit_seq
);
    logic [DEPTH-1:0] match;

    for (genvar i = 0; i < DEPTH; i++) begin : g_match
        assign match[i] = slot_live[i] && slot_known[i] && (slot_seq[i] > store_seq) &&
            (slot_addr[i][ADDR_W-1:REGION_SHIFT] == store_addr[ADDR_W-1:REGION_SHIFT]);
    end

    always_comb begin
        logic [PTR_W-1:0] idx;
        hit     = 1'b0;
        hit_seq = '0;
        for (int k = 0; k < DEPTH; k++) begin
            idx = head + PTR_W'(k);
            if (!hit && match[idx]) begin
                hit     = 1'b1;
                hit_seq = slot_seq[idx];
            end
        end
    end
endmodule

// File: rtl/ldq_vio_record.sv
module ldq_vio_record
    import ldq_pkg::*;
#(
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             store_valid,
    input  logic             hit,
    input  logic [SEQ_W-1:0] hit_seq,
    input  logic             vio_read,
    output logic             store_fault,
    output logic             vio_valid,
    output logic [SEQ_W-1:0] vio_seq
);
    vio_state_e       state;
    logic [SEQ_W-1:0] rec_seq;
    logic             fault_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= VIO_IDLE;
            rec_seq <= '0;
            fault_q <= 1'b0;
        end else begin
            fault_q <= 1'b0;
            unique case (state)
                VIO_IDLE: if (store_valid && hit) begin
                    state   <= VIO_HELD;
                    rec_seq <= hit_seq;
                    fault_q <= 1'b1;
                end
                VIO_HELD: if (vio_read) state <= VIO_IDLE;
                default:  state <= VIO_IDLE;
            endcase
        end
    end

    always_comb begin
        vio_valid   = (state == VIO_HELD);
        vio_seq     = rec_seq;
        store_fault = fault_q;
    end

    p_fault_has_record_r5: assert property (@(posedge clk) disable iff (!rst_n)
        store_fault |-> vio_valid);

    p_held_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vio_valid && !vio_read) |=> (vio_valid && $stable(vio_seq) && !store_fault));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (vio_valid && vio_read) |=> (!vio_valid && !store_fault));
endmodule

// File: rtl/ldq_order_guard.sv
module ldq_order_guard #(
    parameter int DEPTH        = 8,
    parameter int SEQ_W        = 16,
    parameter int ADDR_W       = 32,
    parameter int REGION_SHIFT = 8,
    localparam int PTR_W       = $clog2(DEPTH),
    localparam int CNT_W       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_valid,
    input  logic [SEQ_W-1:0]  alloc_seq,
    input  logic              exec_valid,
    input  logic [SEQ_W-1:0]  exec_seq,
    input  logic [ADDR_W-1:0] exec_addr,
    input  logic              commit_valid,
    input  logic [SEQ_W-1:0]  commit_seq,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    input  logic              store_valid,
    input  logic [SEQ_W-1:0]  store_seq,
    input  logic [ADDR_W-1:0] store_addr,
    input  logic              vio_read,
    input  logic              blk_set,
    input  logic [SEQ_W-1:0]  blk_seq,
    output logic [CNT_W-1:0]  ldq_count,
    output logic              store_fault,
    output logic              vio_valid,
    output logic [SEQ_W-1:0]  vio_seq,
    output logic              blk_active
);
    logic [DEPTH-1:0]             slot_live, slot_known;
    logic [DEPTH-1:0][SEQ_W-1:0]  slot_seq;
    logic [DEPTH-1:0][ADDR_W-1:0] slot_addr;
    logic [PTR_W-1:0]             head;
    logic                         hit;
    logic [SEQ_W-1:0]             hit_seq;

    ldq_entries #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)) u_entries (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
        .exec_valid(exec_valid), .exec_seq(exec_seq), .exec_addr(exec_addr),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .blk_set(blk_set), .blk_seq(blk_seq),
        .slot_live(slot_live), .slot_known(slot_known),
        .slot_seq(slot_seq), .slot_addr(slot_addr),
        .head(head), .count(ldq_count), .blk_active(blk_active)
    );

    ldq_vio_search #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W),
                     .REGION_SHIFT(REGION_SHIFT)) u_search (
        .slot_live(slot_live), .slot_known(slot_known),
        .slot_seq(slot_seq), .slot_addr(slot_addr), .head(head),
        .store_seq(store_seq), .store_addr(store_addr),
        .hit(hit), .hit_seq(hit_seq)
    );

    ldq_vio_record #(.SEQ_W(SEQ_W)) u_record (
        .clk(clk), .rst_n(rst_n),
        .store_valid(store_valid), .hit(hit), .hit_seq(hit_seq),
        .vio_read(vio_read),
        .store_fault(store_fault), .vio_valid(vio_valid), .vio_seq(vio_seq)
    );

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ldq_count <= CNT_W'(DEPTH));
endmodule

// File: tb/sim_ldq_order_guard.sv
module sim_ldq_order_guard;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_valid = 0, exec_valid = 0, commit_valid = 0, squash_valid = 0;
    logic        store_valid = 0, vio_read = 0, blk_set = 0;
    logic [15:0] alloc_seq = 0, exec_seq = 0, commit_seq = 0, squash_seq = 0;
    logic [15:0] store_seq = 0, blk_seq = 0;
    logic [31:0] exec_addr = 0, store_addr = 0;
    logic [3:0]  ldq_count;
    logic        store_fault, vio_valid, blk_active;
    logic [15:0] vio_seq;
    int          n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    ldq_order_guard u0 (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
        .exec_valid(exec_valid), .exec_seq(exec_seq), .exec_addr(exec_addr),
        .commit_valid(commit_valid), .commit_seq(commit_seq),
        .squash_valid(squash_valid), .squash_seq(squash_seq),
        .store_valid(store_valid), .store_seq(store_seq), .store_addr(store_addr),
        .vio_read(vio_read), .blk_set(blk_set), .blk_seq(blk_seq),
        .ldq_count(ldq_count), .store_fault(store_fault), .vio_valid(vio_valid),
        .vio_seq(vio_seq), .blk_active(blk_active)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        alloc_valid = 0; exec_valid = 0; commit_valid = 0; squash_valid = 0;
        store_valid = 0; vio_read = 0; blk_set = 0;
    endtask

    task automatic do_alloc(input int s);
        alloc_valid = 1; alloc_seq = 16'(s); tick();
    endtask

    task automatic do_exec(input int s, input int a);
        exec_valid = 1; exec_seq = 16'(s); exec_addr = 32'(a); tick();
    endtask

    task automatic do_store(input int s, input int a);
        store_valid = 1; store_seq = 16'(s); store_addr = 32'(a); tick();
    endtask

    task automatic do_commit(input int s);
        commit_valid = 1; commit_seq = 16'(s); tick();
    endtask

    task automatic do_read();
        vio_read = 1; tick();
    endtask

    task automatic t_reset();
        chk("R1 count", ldq_count, 0);
        chk("R1 fault", store_fault, 0);
        chk("R1 vio_valid", vio_valid, 0);
        chk("R1 blk", blk_active, 0);
    endtask

    task automatic t_alloc_commit();
        for (int i = 0; i < 8; i++) do_alloc(10 + i);
        chk("R2 fill", ldq_count, 8);
        do_alloc(18);
        chk("R2 full ignored", ldq_count, 8);
        do_commit(12);
        chk("R3 partial commit", ldq_count, 5);
        do_commit(1000);
        chk("R3 commit all", ldq_count, 0);
    endtask

    task automatic t_squash();
        do_alloc(20); do_alloc(21); do_alloc(22); do_alloc(23);
        squash_valid = 1; squash_seq = 21; tick();
        chk("R4 squash", ldq_count, 2);
        squash_valid = 1; squash_seq = 20; alloc_valid = 1; alloc_seq = 30; tick();
        chk("R4 squash with alloc", ldq_count, 2);
        do_exec(30, 'h1000);
        do_store(25, 'h10FF);
        chk("R4 allocated load kept", vio_seq, 30);
        do_read();
        do_commit(1000);
    endtask

    task automatic t_basic();
        do_alloc(40); do_alloc(41); do_alloc(42);
        do_exec(40, 'h2000); do_exec(41, 'h2010); do_exec(42, 'h3000);
        do_store(39, 'h2100);
        chk("R5 other region no fault", store_fault, 0);
        do_store(40, 'h20AB);
        chk("R5 fault", store_fault, 1);
        chk("R5 vio_valid", vio_valid, 1);
        chk("R5 younger only", vio_seq, 41);
        tick();
        chk("R5 single-cycle fault", store_fault, 0);
        do_read();
        chk("R9 read clears", vio_valid, 0);
        do_commit(1000);
    endtask

    task automatic t_unresolved();
        do_alloc(50);
        do_store(49, 'h0);
        chk("R6 unknown address no fault", store_fault, 0);
        chk("R6 no record", vio_valid, 0);
        do_commit(1000);
    endtask

    task automatic t_oldest();
        do_alloc(60); do_alloc(61); do_alloc(62);
        do_exec(62, 'h4000); do_exec(61, 'h4001); do_exec(60, 'h5000);
        do_store(55, 'h40FF);
        chk("R7 oldest match", vio_seq, 61);
    endtask

    task automatic t_held();
        do_store(55, 'h5000);
        chk("R8 held no fault", store_fault, 0);
        chk("R8 held seq stable", vio_seq, 61);
        vio_read = 1; store_valid = 1; store_seq = 55; store_addr = 'h5000; tick();
        chk("R8 read+store clears", vio_valid, 0);
        chk("R8 read+store no fault", store_fault, 0);
        tick();
        chk("R8 no late capture", vio_valid, 0);
        do_store(55, 'h5000);
        chk("R8 later store searched", vio_seq, 60);
        chk("R8 later fault", store_fault, 1);
        do_read();
        do_commit(1000);
    endtask

    task automatic t_blocked();
        blk_set = 1; blk_seq = 70; tick();
        chk("R10 armed", blk_active, 1);
        squash_valid = 1; squash_seq = 80; tick();
        chk("R10 older squash keeps", blk_active, 1);
        squash_valid = 1; squash_seq = 70; tick();
        chk("R10 equal squash keeps", blk_active, 1);
        squash_valid = 1; squash_seq = 65; tick();
        chk("R10 cleared", blk_active, 0);
    endtask

    initial begin
        #100000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_alloc_commit();
        t_squash();
        t_basic();
        t_unresolved();
        t_oldest();
        t_held();
        t_blocked();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule